// File: doc/BRIEF.md
# Cartridge Slot Bus Decoder

This block sits between a 68000-style processor bus and a cartridge slot. It watches the 24-bit address, the address strobe, the read/write line and the two byte-lane data strobes. From these it produces the active-low selects that a cartridge needs: a chip enable for the cartridge memory window, a select for reads in the lower half of the map, a common output enable for reads, one write strobe per byte lane, and a select for a 256-byte I/O window that cartridge hardware such as a bank register can decode.

A slot-sense input tells the decoder whether a cartridge is plugged in. The pin is pulled high, so an empty slot reads as absent. When the pin is grounded, the cartridge chip enable covers the bottom 4 MB. When the pin is high, the same enable moves up to the next 4 MB so that a RAM cartridge can sit there. Each select is decoded from the bus inputs and registered on the bus clock. The registered value is then gated by the live address strobe, so every output goes inactive in the same cycle that the strobe is released.

Top module: `cart_slot_decoder`

## Requirements
- R1: With slotSenseN low (cartridge present), cartSelN goes low for reads and writes to $000000-$3FFFFF and stays high for $400000-$7FFFFF.
- R2: With slotSenseN high (slot empty), cartSelN goes low for reads and writes to $400000-$7FFFFF and stays high for $000000-$3FFFFF.
- R3: lowMemSelN goes low only for read cycles (busRead=1) in $000000-$7FFFFF and never for write cycles.
- R4: readEnN goes low for read cycles anywhere in $000000-$DFFFFF and stays high for reads at $E00000 and above and for all writes.
- R5: ioWinSelN goes low for reads or writes to $A13000-$A130FF and stays high at $A12FFF and $A13100.
- R6: loWrN goes low only when busRead=0 and loStrobeN=0; hiWrN goes low only when busRead=0 and hiStrobeN=0; neither depends on the address and neither goes low on a read.
- R7: While addrStrobeN is high every output is high; when addrStrobeN rises, all outputs are high in that same cycle without waiting for a clock edge.
- R8: A select goes low one clock edge after the edge at which addrStrobeN=0 and its decode condition are first sampled; before that edge the outputs are still high.
- R9: A synchronous active-high rst forces every output high at the next clock edge, even while addrStrobeN is held low.
- R10: An address outside every window (for example $FF0000) leaves cartSelN, lowMemSelN, readEnN and ioWinSelN high; only the write strobes can respond there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 24 | Byte address of the bus cycle |
| addrStrobeN | input | 1 | Address strobe, low while busAddr is valid |
| busRead | input | 1 | 1 = read cycle, 0 = write cycle |
| hiStrobeN | input | 1 | Upper byte-lane data strobe, active low |
| loStrobeN | input | 1 | Lower byte-lane data strobe, active low |
| slotSenseN | input | 1 | Cartridge present when low; pulled high when empty |
| cartSelN | output | 1 | Cartridge chip enable, active low |
| lowMemSelN | output | 1 | Low-memory read select, active low |
| readEnN | output | 1 | Common read output enable, active low |
| hiWrN | output | 1 | Upper byte write strobe, active low |
| loWrN | output | 1 | Lower byte write strobe, active low |
| ioWinSelN | output | 1 | I/O window select, active low |

## Verification
Every select is due one clock edge after the inputs are sampled with the address strobe low. The bench therefore changes inputs on the falling clock edge and reads the outputs on the following falling edge, after exactly one rising edge. Release of the address strobe acts without a clock, so that check is made one time step after the strobe rises. A separate check just before the first rising edge confirms that nothing has appeared early. Reset takes effect at the next rising edge and is read on the falling edge after it.

// File: rtl/cart_slot_pkg.sv
package cart_slot_pkg;

  // Strobes handed from the control module to the datapath.
  typedef struct packed {
    logic busValid;   // address strobe asserted
    logic readCyc;    // valid read cycle
    logic writeCyc;   // valid write cycle
    logic [1:0] laneWr; // per-lane write request, [1]=upper, [0]=lower
  } bus_strobe_t;

  // Active-low select vector, bit order fixed for the whole project.
  typedef struct packed {
    logic cartN;
    logic lowMemN;
    logic readEnN;
    logic hiWrN;
    logic loWrN;
    logic ioWinN;
  } sel_vec_t;

  localparam sel_vec_t SEL_IDLE = '{default: 1'b1};

endpackage

// File: rtl/cart_slot_ctrl.sv
module cart_slot_ctrl
  import cart_slot_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic addrStrobeN,
  input  logic busRead,
  input  logic [NUM_LANES-1:0] laneStrobeN,
  output bus_strobe_t strobes
);

  logic valid;
  logic [NUM_LANES-1:0] laneReq;

  assign valid = ~addrStrobeN;

  // One write request per byte lane: write cycle and the lane strobe.
  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    assign laneReq[lane] = valid & ~busRead & ~laneStrobeN[lane];
  end

  always_comb begin
    strobes          = '0;
    strobes.busValid = valid;
    strobes.readCyc  = valid & busRead;
    strobes.writeCyc = valid & ~busRead;
    strobes.laneWr   = laneReq;
  end

endmodule

// File: rtl/cart_slot_datapath.sv
module cart_slot_datapath
  import cart_slot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] CART_NEAR_LAST = 24'h3FFFFF,
  parameter logic [ADDR_W-1:0] CART_FAR_FIRST = 24'h400000,
  parameter logic [ADDR_W-1:0] CART_FAR_LAST  = 24'h7FFFFF,
  parameter logic [ADDR_W-1:0] LOWMEM_LAST    = 24'h7FFFFF,
  parameter logic [ADDR_W-1:0] READEN_LAST    = 24'hDFFFFF,
  parameter logic [ADDR_W-1:0] IOWIN_FIRST    = 24'hA13000,
  parameter int IOWIN_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic slotSenseN,
  input  bus_strobe_t strobes,
  output sel_vec_t selOut
);

  localparam int IO_TAG_W = ADDR_W - IOWIN_BITS;

  logic inNear, inFar, inCart, inLowMem, inReadEn, inIoWin;
  sel_vec_t nextSel, selReg;

  // Address range compares.
  always_comb begin
    inNear   = busAddr <= CART_NEAR_LAST;
    inFar    = (busAddr >= CART_FAR_FIRST) && (busAddr <= CART_FAR_LAST);
    inCart   = slotSenseN ? inFar : inNear;
    inLowMem = busAddr <= LOWMEM_LAST;
    inReadEn = busAddr <= READEN_LAST;
    inIoWin  = busAddr[ADDR_W-1:IOWIN_BITS] == IOWIN_FIRST[ADDR_W-1:IOWIN_BITS];
  end

  // Qualify ranges with the cycle strobes; active-low encoding.
  always_comb begin
    nextSel         = SEL_IDLE;
    nextSel.cartN   = ~(strobes.busValid & inCart);
    nextSel.lowMemN = ~(strobes.readCyc & inLowMem);
    nextSel.readEnN = ~(strobes.readCyc & inReadEn);
    nextSel.hiWrN   = ~strobes.laneWr[1];
    nextSel.loWrN   = ~strobes.laneWr[0];
    nextSel.ioWinN  = ~(strobes.busValid & inIoWin);
  end

  always_ff @(posedge clk) begin
    if (rst || !strobes.busValid) selReg <= SEL_IDLE;
    else                          selReg <= nextSel;
  end

  // Release immediately when the strobe goes away.
  assign selOut = selReg | {$bits(sel_vec_t){~strobes.busValid}};

  logic unusedTag;
  assign unusedTag = ^IO_TAG_W;

endmodule

// File: rtl/cart_slot_decoder.sv
module cart_slot_decoder
  import cart_slot_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic addrStrobeN,
  input  logic busRead,
  input  logic hiStrobeN,
  input  logic loStrobeN,
  input  logic slotSenseN,
  output logic cartSelN,
  output logic lowMemSelN,
  output logic readEnN,
  output logic hiWrN,
  output logic loWrN,
  output logic ioWinSelN
);

  bus_strobe_t strobes;
  sel_vec_t selOut;

  cart_slot_ctrl #(.NUM_LANES(2)) u_ctrl (
    .addrStrobeN(addrStrobeN),
    .busRead(busRead),
    .laneStrobeN({hiStrobeN, loStrobeN}),
    .strobes(strobes)
  );

  cart_slot_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk),
    .rst(rst),
    .busAddr(busAddr),
    .slotSenseN(slotSenseN),
    .strobes(strobes),
    .selOut(selOut)
  );

  assign cartSelN   = selOut.cartN;
  assign lowMemSelN = selOut.lowMemN;
  assign readEnN    = selOut.readEnN;
  assign hiWrN      = selOut.hiWrN;
  assign loWrN      = selOut.loWrN;
  assign ioWinSelN  = selOut.ioWinN;

endmodule

// File: rtl/cart_slot_checker.sv
module cart_slot_checker #(
  parameter int ADDR_W = 24
) (
  input logic clk,
  input logic rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic addrStrobeN,
  input logic busRead,
  input logic hiStrobeN,
  input logic loStrobeN,
  input logic slotSenseN,
  input logic cartSelN,
  input logic lowMemSelN,
  input logic readEnN,
  input logic hiWrN,
  input logic loWrN,
  input logic ioWinSelN
);

  logic allHigh;
  assign allHigh = cartSelN & lowMemSelN & readEnN & hiWrN & loWrN & ioWinSelN;

  a_r9_reset_idle: assert property (@(posedge clk) rst |=> allHigh);

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    $rose(addrStrobeN) |-> allHigh);

  a_r1_cart_near: assert property (@(posedge clk) disable iff (rst)
    (!addrStrobeN && !$past(rst) && $past(!addrStrobeN && !slotSenseN && busAddr <= 24'h3FFFFF))
      |-> !cartSelN);

  a_r2_cart_far_only: assert property (@(posedge clk) disable iff (rst)
    $past(slotSenseN && busAddr <= 24'h3FFFFF) |-> cartSelN);

  a_r3_lowmem_read: assert property (@(posedge clk) disable iff (rst)
    (!addrStrobeN && !$past(rst) && $past(!addrStrobeN && busRead && busAddr <= 24'h7FFFFF))
      |-> !lowMemSelN);

  a_r5_io_window: assert property (@(posedge clk) disable iff (rst)
    (!addrStrobeN && !$past(rst) && $past(!addrStrobeN && busAddr[23:8] == 16'hA130))
      |-> !ioWinSelN);

  a_r6_no_write_on_read: assert property (@(posedge clk) disable iff (rst)
    $past(busRead) |-> (hiWrN && loWrN));

endmodule

bind cart_slot_decoder cart_slot_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cart_slot_decoder_test.sv
`timescale 1ns/1ps
module cart_slot_decoder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] busAddr = '0;
  logic addrStrobeN = 1'b1;
  logic busRead = 1'b1;
  logic hiStrobeN = 1'b1;
  logic loStrobeN = 1'b1;
  logic slotSenseN = 1'b0;
  logic cartSelN, lowMemSelN, readEnN, hiWrN, loWrN, ioWinSelN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cart_slot_decoder uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .addrStrobeN(addrStrobeN),
    .busRead(busRead), .hiStrobeN(hiStrobeN), .loStrobeN(loStrobeN),
    .slotSenseN(slotSenseN), .cartSelN(cartSelN), .lowMemSelN(lowMemSelN),
    .readEnN(readEnN), .hiWrN(hiWrN), .loWrN(loWrN), .ioWinSelN(ioWinSelN)
  );

  // Output vector order: cart, lowMem, readEn, loWr, hiWr, ioWin.
  function automatic logic [5:0] outs();
    return {cartSelN, lowMemSelN, readEnN, loWrN, hiWrN, ioWinSelN};
  endfunction

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b (cart,low,rd,lwr,uwr,io)", req, got, exp);
    end
  endtask

  typedef struct packed {
    logic [23:0] addr;
    logic rd;
    logic uds;
    logic lds;
    logic sense;
    logic [5:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{24'h000000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000111}, // R1 R3 R4
    '{24'h3FFFFE, 1'b0, 1'b0, 1'b1, 1'b0, 6'b011101}, // R1 R6 upper only
    '{24'h400000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100111}, // R1 outside near
    '{24'h400000, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000111}, // R2
    '{24'h000000, 1'b1, 1'b0, 1'b0, 1'b1, 6'b100111}, // R2
    '{24'h7FFFFE, 1'b0, 1'b0, 1'b0, 1'b1, 6'b011001}, // R2 R3 R6
    '{24'h800000, 1'b1, 1'b0, 1'b0, 1'b1, 6'b110111}, // R3 R4
    '{24'hDFFFFE, 1'b1, 1'b0, 1'b0, 1'b0, 6'b110111}, // R4
    '{24'hE00000, 1'b1, 1'b0, 1'b0, 1'b0, 6'b111111}, // R4 R10
    '{24'hA13000, 1'b0, 1'b1, 1'b0, 1'b0, 6'b111010}, // R5 R6 lower only
    '{24'hA130FF, 1'b1, 1'b0, 1'b0, 1'b0, 6'b110110}, // R5
    '{24'hA13100, 1'b1, 1'b0, 1'b0, 1'b0, 6'b110111}, // R5
    '{24'hA12FFF, 1'b0, 1'b0, 1'b0, 1'b0, 6'b111001}, // R5 R6
    '{24'hFF0000, 1'b0, 1'b1, 1'b0, 1'b0, 6'b111011}, // R10 R6
    '{24'h3FFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 6'b100111}, // R2 boundary
    '{24'h7FFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100111}  // R1 R3 boundary
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", outs(), 6'b111111);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      busAddr = VECS[i].addr; busRead = VECS[i].rd;
      hiStrobeN = VECS[i].uds; loStrobeN = VECS[i].lds;
      slotSenseN = VECS[i].sense; addrStrobeN = 1'b0;
      #1 check("R8 before edge", outs(), 6'b111111);
      @(negedge clk);
      check($sformatf("R1-R6,R10 vector %0d", i), outs(), VECS[i].exp);
      addrStrobeN = 1'b1;
      #1 check("R7 same-cycle release", outs(), 6'b111111);
      @(negedge clk);
    end

    // R7: decode-worthy address with strobe high never selects.
    busAddr = 24'hA13004; busRead = 1'b0; hiStrobeN = 1'b0; loStrobeN = 1'b0;
    slotSenseN = 1'b0; addrStrobeN = 1'b1;
    @(negedge clk);
    check("R7 strobe high idle", outs(), 6'b111111);

    // R8: held cycle stays asserted over several edges.
    busAddr = 24'h000100; busRead = 1'b1; addrStrobeN = 1'b0;
    @(negedge clk);
    check("R8 one edge", outs(), 6'b000111);
    @(negedge clk);
    check("R8 held", outs(), 6'b000111);

    // R9: reset during an active cycle.
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset mid-cycle", outs(), 6'b111111);
    rst = 1'b0;
    @(negedge clk);
    check("R9 recover after reset", outs(), 6'b000111);
    addrStrobeN = 1'b1;

    // R3/R6: write to low memory never selects lowMem or readEn.
    @(negedge clk);
    busAddr = 24'h200000; busRead = 1'b0; loStrobeN = 1'b1; hiStrobeN = 1'b1;
    addrStrobeN = 1'b0;
    @(negedge clk);
    check("R3 R6 write no lanes", outs(), 6'b011111);
    addrStrobeN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule